// File: doc/BRIEF.md
# Branch Record Ring with Wide Top-of-Stack Pointer

This block keeps a history of taken branches. Each record holds a source address and a target address. Records go into a circular array of 2^M slots. A top-of-stack counter points at the newest record. The counter is wider than the slot index: its low M bits pick the slot, and its upper bits count how many times the ring has wrapped. Because of those upper bits, an old pointer value can never be mistaken for a current one.

When a context-switch pulse arrives, a snapshot register stores the current counter value. Software reads the history backward from the newest record. It gives a step index i, and one cycle later the block returns the record at slot (tos - i) mod 2^M together with a valid flag.

In task mode the valid flag is set only while (tos - i) is strictly greater than the snapshot. This stops software from reading records that belong to the previous context. In cpu mode every written slot is reported valid. A slot that has not been written since reset always reads back as invalid.

Top module: `brec_ring`

## Requirements
- R1: After reset, `tos_o` and `snap_o` are zero, and every read returns `rd_valid_o` = 0 in both modes.
- R2: A cycle with `rec_i` = 1 adds one to `tos_o`. The same cycle writes the source/target pair into slot (new tos) mod 2^M.
- R3: A read request (`rd_en_i` = 1, step i) returns, on the next clock, the pair stored in slot (tos - i) mod 2^M. The read outputs keep their values in cycles without a read request.
- R4: A slot that has not been written since reset reads back with `rd_valid_o` = 0, whatever the mode.
- R5: A cycle with `ctxsw_i` = 1 loads `snap_o` with the value `tos_o` had before that edge. This holds even when `rec_i` is also high in the same cycle. In cycles without `ctxsw_i`, the snapshot does not change.
- R6: In task mode (`rd_task_i` = 1), a read of a written slot is valid only if (tos - i) > snapshot. The comparison is unsigned at the full counter width.
- R7: In cpu mode (`rd_task_i` = 0), every written slot reads back valid, whatever the snapshot holds.
- R8: A read requested in the same cycle as a record strobe uses the tos value and the slot contents from before the write.
- R9: After more than 2^M records, the oldest slots hold the newest data. `tos_o` keeps counting past 2^M without folding back to zero.
- R10: If the snapshot was taken more than 2^M records ago, a task-mode read reports all 2^M slots valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_i | input | 1 | Record strobe for one taken branch |
| rec_src_i | input | AW | Branch source address |
| rec_dst_i | input | AW | Branch target address |
| ctxsw_i | input | 1 | Context-switch pulse; captures tos into the snapshot |
| rd_en_i | input | 1 | Read request |
| rd_step_i | input | M | Backward step i from the newest record |
| rd_task_i | input | 1 | 1 = task mode (snapshot limit), 0 = cpu mode |
| rd_src_o | output | AW | Source address read back |
| rd_dst_o | output | AW | Target address read back |
| rd_valid_o | output | 1 | Read-back record is valid |
| tos_o | output | PW | Top-of-stack counter |
| snap_o | output | PW | Snapshot of tos taken at the last context switch |

## Verification
The ring is read in four situations:
- Partly filled. This separates written slots from unwritten ones.
- After a context switch with a few new records. This shows where the task-mode limit falls, and that cpu mode ignores the snapshot.
- With a record strobe landing on the read cycle, and with a context-switch pulse landing on the strobe. This checks that both use pre-write state.
- After many wraps. This separates the wide counter from a folded index, both when the snapshot is far in the past and when it is recent.

// File: rtl/brec_ring.sv
module brec_ring #(
  parameter int M  = 3,
  parameter int PW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_i,
  input  logic [AW-1:0] rec_src_i,
  input  logic [AW-1:0] rec_dst_i,
  input  logic          ctxsw_i,
  input  logic          rd_en_i,
  input  logic [M-1:0]  rd_step_i,
  input  logic          rd_task_i,
  output logic [AW-1:0] rd_src_o,
  output logic [AW-1:0] rd_dst_o,
  output logic          rd_valid_o,
  output logic [PW-1:0] tos_o,
  output logic [PW-1:0] snap_o
);
  localparam int N = 1 << M;

  logic [AW-1:0] src_mem [N];
  logic [AW-1:0] dst_mem [N];
  logic [N-1:0]  filled;
  logic [PW-1:0] tos, snap;

  wire [PW-1:0] tos_nxt  = tos + PW'(1);
  wire [M-1:0]  wr_slot  = tos_nxt[M-1:0];
  wire [PW-1:0] rd_ptr   = tos - PW'(rd_step_i);
  wire [M-1:0]  rd_slot  = rd_ptr[M-1:0];
  wire          in_task  = rd_ptr > snap;
  wire          rd_ok    = filled[rd_slot] && (!rd_task_i || in_task);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos    <= '0;
      snap   <= '0;
      filled <= '0;
    end else begin
      if (rec_i) begin
        tos             <= tos_nxt;
        filled[wr_slot] <= 1'b1;
      end
      if (ctxsw_i) snap <= tos;
    end
  end

  always_ff @(posedge clk) begin
    if (rec_i) begin
      src_mem[wr_slot] <= rec_src_i;
      dst_mem[wr_slot] <= rec_dst_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_src_o   <= '0;
      rd_dst_o   <= '0;
      rd_valid_o <= 1'b0;
    end else if (rd_en_i) begin
      rd_src_o   <= src_mem[rd_slot];
      rd_dst_o   <= dst_mem[rd_slot];
      rd_valid_o <= rd_ok;
    end
  end

  assign tos_o  = tos;
  assign snap_o = snap;

  p_tos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_i |=> tos_o == $past(tos_o) + PW'(1));
  p_tos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_i |=> $stable(tos_o));
  p_snap_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctxsw_i |=> snap_o == $past(tos_o));
  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctxsw_i |=> $stable(snap_o));
  p_task_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_task_i && (tos_o - PW'(rd_step_i)) <= snap_o) |=> !rd_valid_o);
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_valid_o) && $stable(rd_src_o));
  p_cpu_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_task_i && (&filled)) |=> rd_valid_o);
endmodule

// File: tb/brec_ring_bench.sv
module brec_ring_bench;
  localparam int M  = 3;
  localparam int PW = 16;
  localparam int AW = 32;
  localparam int N  = 1 << M;

  logic clk = 0, rst_n = 0;
  logic rec = 0, ctx = 0, rd_en = 0, rd_task = 0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [M-1:0] step = '0;
  logic [AW-1:0] rsrc, rdst;
  logic rvalid;
  logic [PW-1:0] tos, snap;

  int checks = 0, fails = 0, rec_no = 0;
  logic [AW-1:0] m_src [N];
  logic [AW-1:0] m_dst [N];
  logic [N-1:0]  m_fill = '0;
  logic [PW-1:0] m_tos = '0, m_snap = '0;

  always #5 clk = ~clk;

  brec_ring #(.M(M), .PW(PW), .AW(AW)) u_brec_ring (
    .clk(clk), .rst_n(rst_n), .rec_i(rec), .rec_src_i(src), .rec_dst_i(dst),
    .ctxsw_i(ctx), .rd_en_i(rd_en), .rd_step_i(step), .rd_task_i(rd_task),
    .rd_src_o(rsrc), .rd_dst_o(rdst), .rd_valid_o(rvalid),
    .tos_o(tos), .snap_o(snap));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_rec();
    logic [PW-1:0] t;
    t = m_tos + PW'(1);
    m_src[t[M-1:0]] = src;
    m_dst[t[M-1:0]] = dst;
    m_fill[t[M-1:0]] = 1'b1;
    m_tos = t;
  endtask

  task automatic exp_valid(input logic [M-1:0] s, input logic tk, output logic v,
                           output logic [M-1:0] sl);
    logic [PW-1:0] p;
    p = m_tos - PW'(s);
    sl = p[M-1:0];
    v = m_fill[sl] && (!tk || p > m_snap);
  endtask

  task automatic do_rec(int cnt);
    for (int k = 0; k < cnt; k++) begin
      rec_no++;
      src = 32'h1000_0000 + rec_no;
      dst = 32'h2000_0000 + rec_no;
      rec = 1;
      model_rec();
      @(negedge clk);
      rec = 0;
    end
  endtask

  task automatic do_ctx();
    ctx = 1;
    m_snap = m_tos;
    @(negedge clk);
    ctx = 0;
  endtask

  task automatic rd_chk(string req, logic [M-1:0] s, logic tk);
    logic v;
    logic [M-1:0] sl;
    exp_valid(s, tk, v, sl);
    step = s; rd_task = tk; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(req, rvalid, v);
    if (v) begin
      chk(req, rsrc, m_src[sl]);
      chk(req, rdst, m_dst[sl]);
    end
  endtask

  task automatic t_reset();
    chk("R1 tos", tos, 0);
    chk("R1 snap", snap, 0);
    rd_chk("R1", 0, 0);
    rd_chk("R1", 0, 1);
  endtask

  task automatic t_fill();
    do_rec(5);
    chk("R2 tos", tos, 5);
    for (int s = 0; s < N; s++) rd_chk(s < 5 ? "R3" : "R4", M'(s), 0);
    chk("R4 unwritten", rvalid, 0);
  endtask

  task automatic t_hold();
    logic [AW-1:0] keep;
    rd_chk("R3", 1, 0);
    keep = rsrc;
    @(negedge clk);
    @(negedge clk);
    chk("R3 hold", rsrc, keep);
    chk("R3 hold valid", rvalid, 1);
  endtask

  task automatic t_ctx();
    do_ctx();
    chk("R5 snap", snap, 5);
    do_rec(2);
    for (int s = 0; s < 4; s++) rd_chk("R6", M'(s), 1);
    rd_chk("R7", 2, 0);
    chk("R7 cpu ignores snap", rvalid, 1);
  endtask

  task automatic t_same();
    logic v;
    logic [M-1:0] sl;
    exp_valid(0, 0, v, sl);
    rec_no++;
    src = 32'h1000_0000 + rec_no;
    dst = 32'h2000_0000 + rec_no;
    step = 0; rd_task = 0; rd_en = 1; rec = 1;
    @(negedge clk);
    rd_en = 0; rec = 0;
    chk("R8 valid", rvalid, v);
    chk("R8 src", rsrc, m_src[sl]);
    model_rec();
    chk("R8 tos after", tos, m_tos);
    rec_no++;
    src = 32'h1000_0000 + rec_no;
    dst = 32'h2000_0000 + rec_no;
    rec = 1; ctx = 1;
    m_snap = m_tos;
    model_rec();
    @(negedge clk);
    rec = 0; ctx = 0;
    chk("R5 same-cycle snap", snap, m_snap);
  endtask

  task automatic t_wrap();
    do_rec(20);
    chk("R9 tos", tos, m_tos);
    for (int s = 0; s < N; s++) rd_chk("R9", M'(s), 0);
    for (int s = 0; s < N; s++) rd_chk("R10", M'(s), 1);
    chk("R10 oldest valid", rvalid, 1);
    do_ctx();
    do_rec(3);
    for (int s = 0; s < N; s++) rd_chk("R6 wrap", M'(s), 1);
    chk("R6 old context hidden", rvalid, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_hold();
    t_ctx();
    t_same();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule